// File: doc/BRIEF.md
# Configuration EEPROM Checksum Verifier

This block walks a configuration EEPROM image word by word and checks that it is intact. It fetches a fixed number of 16-bit data words, starting at address 0 and counting up, and then one checksum word at the next address. A request line and an address are held until the memory answers with a one-cycle valid strobe. Every data word is folded by adding its two bytes modulo 256, and the folds are summed modulo 256. The checksum word is good only when its low byte is 55h and its high byte is the two's complement of the fold sum plus 55h.

There are two ways to start a pass. A load pass also hands each data word to a configuration-write port as it arrives. A self-test pass reads and checks the same words but never writes. Each mode has its own busy bit, which reads 1 for the whole pass. A single fail flag reports the result of the last pass.

Top module: `cfg_csum_verifier`

## Requirements
- R1: With a correct checksum word, the pass ends with fail_flag at 0. An example: data words 1234h and 5678h with all other data words 0000h give checksum word 9755h. The high byte is the two's complement of (sum of hi+lo per word, mod 256) + 55h.
- R2: A checksum word whose low byte is not 55h sets fail_flag to 1 at the end of the pass.
- R3: A checksum word whose high byte differs from the value defined in R1 sets fail_flag to 1 at the end of the pass.
- R4: Reads go out to addresses 0, 1, ..., N_DATA in that order, and each address is read once. rd_req and rd_addr hold steady until rd_valid arrives.
- R5: In load mode, data word k appears on the write port (cfg_we=1, cfg_addr=k, cfg_data=word) in the cycle after it is accepted. The writes come in ascending order, and the checksum word is never written.
- R6: In self-test mode, cfg_we stays 0 throughout.
- R7: The busy bit of the started mode reads 1 from the cycle after the start request. It returns to 0 in the cycle after the checksum word is accepted. At most one busy bit is 1 at any time.
- R8: A start request of either mode that arrives while a pass is running is ignored. The running pass keeps its mode, its address sequence and its result.
- R9: fail_flag is cleared when a new pass starts. While the block is idle, fail_flag holds its value.
- R10: After reset, including a reset in the middle of a pass, both busy bits, fail_flag, rd_req and cfg_we are 0.
- R11: A load pass with a bad checksum still writes all N_DATA words, keeps them written, and sets fail_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_start | input | 1 | Start pulse for a load pass (write of 1 to the load bit) |
| test_start | input | 1 | Start pulse for a self-test pass (write of 1 to the test bit) |
| rd_data | input | 16 | Word returned by the EEPROM reader |
| rd_valid | input | 1 | rd_data is valid for the address now requested |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_addr | output | ADDR_W | Word address being requested |
| cfg_we | output | 1 | Configuration write strobe (load mode only) |
| cfg_addr | output | ADDR_W | Index of the configuration word being written |
| cfg_data | output | 16 | Configuration word being written |
| load_busy | output | 1 | Load bit read-back: 1 while a load pass runs |
| test_busy | output | 1 | Self-test bit read-back: 1 while a self-test runs |
| fail_flag | output | 1 | Read-only result: 1 if the last pass saw a bad checksum |

## Verification
If the fold accumulator is corrupted, the only port that shows it is fail_flag, and only at the end of the pass. For that reason every pass is set up with a known-good or known-bad image, including images with all bytes FFh and all bytes 00h that push the sum through its wraparound. If the word counter or the mode register goes wrong, the effect shows up at once on rd_addr, on a missing or extra cfg_we pulse, or on a busy bit. The bench compares these against the memory image on every cycle of a pass. The busy fall is timed to the exact cycle after the checksum word is delivered, so a stalled or early exit in the sequencer is caught within one cycle.

// File: rtl/cfg_csum_pkg.sv
package cfg_csum_pkg;

  localparam logic [7:0] CSUM_SEED = 8'h55;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_READ = 1'b1
  } phase_e;

  typedef enum logic {
    OP_TEST = 1'b0,
    OP_LOAD = 1'b1
  } op_e;

  // Modulo-256 sum of the two bytes of one word.
  function automatic logic [7:0] fold_word(input logic [15:0] w);
    return 8'(w[15:8] + w[7:0]);
  endfunction

endpackage

// File: rtl/csum_rst_sync.sv
module csum_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/csum_seq.sv
module csum_seq
  import cfg_csum_pkg::*;
#(
  parameter int N_DATA = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              test_start,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              accept,
  output logic              at_csum,
  output logic              op_start,
  output op_e               op_mode,
  output logic              load_busy,
  output logic              test_busy
);

  localparam int IDX_W = $clog2(N_DATA + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DATA);

  phase_e          phase_q, phase_d;
  op_e             mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic            idx_en, mode_en;

  // Next-state logic
  always_comb begin
    phase_d  = phase_q;
    mode_d   = mode_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    mode_en  = 1'b0;
    op_start = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (load_start || test_start) begin
          op_start = 1'b1;
          phase_d  = PH_READ;
          mode_d   = load_start ? OP_LOAD : OP_TEST;
          mode_en  = 1'b1;
          idx_d    = '0;
          idx_en   = 1'b1;
        end
      end
      PH_READ: begin
        if (rd_valid) begin
          if (idx_q == LAST_IDX) begin
            phase_d = PH_IDLE;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // State registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OP_TEST;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign rd_req    = (phase_q == PH_READ);
  assign rd_addr   = ADDR_W'(idx_q);
  assign accept    = rd_req && rd_valid;
  assign at_csum   = (idx_q == LAST_IDX);
  assign op_mode   = mode_q;
  assign load_busy = rd_req && (mode_q == OP_LOAD);
  assign test_busy = rd_req && (mode_q == OP_TEST);

endmodule

// File: rtl/csum_accum.sv
module csum_accum
  import cfg_csum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_start,
  input  logic        accept,
  input  logic        at_csum,
  input  logic [15:0] rd_data,
  output logic        fail_flag
);

  logic [7:0] sum_q, sum_d;
  logic       sum_en;
  logic       fail_q, fail_d;
  logic       fail_en;
  logic       verdict_bad;

  // Good image: low byte equals the seed and hi + sum + seed wraps to zero.
  assign verdict_bad = (rd_data[7:0] != CSUM_SEED) ||
                       (8'(rd_data[15:8] + sum_q + CSUM_SEED) != 8'h00);

  always_comb begin
    sum_d   = sum_q;
    sum_en  = 1'b0;
    fail_d  = fail_q;
    fail_en = 1'b0;
    if (op_start) begin
      sum_d   = '0;
      sum_en  = 1'b1;
      fail_d  = 1'b0;
      fail_en = 1'b1;
    end else if (accept) begin
      if (at_csum) begin
        fail_d  = verdict_bad;
        fail_en = 1'b1;
      end else begin
        sum_d  = 8'(sum_q + fold_word(rd_data));
        sum_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (fail_en) begin
      fail_q <= fail_d;
    end
  end

  assign fail_flag = fail_q;

endmodule

// File: rtl/csum_wr_port.sv
module csum_wr_port
  import cfg_csum_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              at_csum,
  input  op_e               op_mode,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [15:0]       word_data,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [15:0]       cfg_data
);

  logic wr_fire;

  assign wr_fire = accept && !at_csum && (op_mode == OP_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_we <= 1'b0;
    end else begin
      cfg_we <= wr_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_addr <= '0;
      cfg_data <= '0;
    end else if (wr_fire) begin
      cfg_addr <= word_addr;
      cfg_data <= word_data;
    end
  end

endmodule

// File: rtl/cfg_csum_verifier.sv
module cfg_csum_verifier
  import cfg_csum_pkg::*;
#(
  parameter int N_DATA = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_start,
  input  logic              test_start,
  input  logic [15:0]       rd_data,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [15:0]       cfg_data,
  output logic              load_busy,
  output logic              test_busy,
  output logic              fail_flag
);

  logic rst_sync_n;
  logic accept;
  logic at_csum;
  logic op_start;
  op_e  op_mode;

  csum_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  csum_seq #(.N_DATA(N_DATA), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_start (load_start),
    .test_start (test_start),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .accept     (accept),
    .at_csum    (at_csum),
    .op_start   (op_start),
    .op_mode    (op_mode),
    .load_busy  (load_busy),
    .test_busy  (test_busy)
  );

  csum_accum u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op_start  (op_start),
    .accept    (accept),
    .at_csum   (at_csum),
    .rd_data   (rd_data),
    .fail_flag (fail_flag)
  );

  csum_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .at_csum   (at_csum),
    .op_mode   (op_mode),
    .word_addr (rd_addr),
    .word_data (rd_data),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data)
  );

endmodule

// File: rtl/cfg_csum_verifier_checker.sv
module cfg_csum_verifier_checker #(
  parameter int N_DATA = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_start,
  input logic              test_start,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              cfg_we,
  input logic              load_busy,
  input logic              test_busy,
  input logic              fail_flag
);

  // Request and address wait for the answer.
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_addr_in_image_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr <= ADDR_W'(N_DATA)));

  // Writes only come out of a load pass.
  assert_write_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> load_busy);

  assert_no_write_in_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_busy |-> !cfg_we);

  assert_single_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_busy, test_busy}));

  assert_busy_matches_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req == (load_busy || test_busy));

  assert_load_ignored_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (test_busy && load_start) |=> !load_busy);

  assert_test_ignored_in_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && test_start) |=> !test_busy);

  assert_fail_held_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && !test_busy && !load_start && !test_start) |=> $stable(fail_flag));

  assert_fail_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && !test_busy && (load_start || test_start)) |=> !fail_flag);

endmodule

bind cfg_csum_verifier cfg_csum_verifier_checker #(
  .N_DATA (N_DATA),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .load_start (load_start),
  .test_start (test_start),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .rd_addr    (rd_addr),
  .cfg_we     (cfg_we),
  .load_busy  (load_busy),
  .test_busy  (test_busy),
  .fail_flag  (fail_flag)
);

// File: tb/cfg_csum_verifier_bench.sv
module cfg_csum_verifier_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int AW         = 8;
  localparam int NV         = 8;

  typedef struct packed {
    logic        is_load;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [15:0] w3;
    logic [15:0] cs;
    logic        exp_fail;
  } vec_t;

  // Checksum words worked out by hand from R1.
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 16'h9755, 1'b0}, // R1 example, test
    '{1'b1, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 16'h9755, 1'b0}, // R1 example, load
    '{1'b0, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 16'h9754, 1'b1}, // R2 low byte
    '{1'b1, 16'h1234, 16'h5678, 16'h0000, 16'h0000, 16'h9855, 1'b1}, // R3 + R11
    '{1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hB355, 1'b0}, // R1 wrap
    '{1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hAB55, 1'b0}, // R1 zeros
    '{1'b0, 16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h8755, 1'b0}, // R1 mixed
    '{1'b0, 16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h0055, 1'b1}  // R3 high byte
  };

  logic          clk;
  logic          rst_n;
  logic          load_start;
  logic          test_start;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [15:0]   cfg_data;
  logic          load_busy;
  logic          test_busy;
  logic          fail_flag;

  cfg_csum_verifier #(.N_DATA(N), .ADDR_W(AW)) u_cfg_csum_verifier (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .test_start (test_start),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_data   (cfg_data),
    .load_busy  (load_busy),
    .test_busy  (test_busy),
    .fail_flag  (fail_flag)
  );

  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;
  logic [15:0] mem [0:N];
  int          lat = 0;
  int          wcnt = 0;
  int          resp_next = 0;
  int          addr_err = 0;
  int          issue_cyc = -10;
  int          wr_cnt = 0;
  int          wr_err = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // EEPROM reader model: answers after lat idle cycles, checks order (R4).
  initial begin
    rd_valid = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_valid = 1'b0;
        wcnt     = 0;
      end else if (rd_valid) begin
        rd_valid = 1'b0;
      end else if (rd_req) begin
        if (wcnt >= lat) begin
          if (int'(rd_addr) != resp_next) addr_err++;
          rd_data  = (int'(rd_addr) <= N) ? mem[rd_addr] : 16'hDEAD;
          rd_valid = 1'b1;
          if (int'(rd_addr) == N) issue_cyc = cyc;
          resp_next++;
          wcnt = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // Configuration write monitor (R5).
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cfg_we) begin
        if (int'(cfg_addr) != wr_cnt || int'(cfg_addr) >= N ||
            cfg_data != mem[cfg_addr]) wr_err++;
        wr_cnt++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    load_start = 1'b0;
    test_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic start_op(input logic is_load);
    @(negedge clk);
    resp_next = 0;
    wr_cnt    = 0;
    wr_err    = 0;
    addr_err  = 0;
    issue_cyc = -10;
    if (is_load) load_start = 1'b1; else test_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    test_start = 1'b0;
  endtask

  task automatic wait_done(output bit ok_timing);
    ok_timing = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (!load_busy && !test_busy) begin
        ok_timing = (cyc == issue_cyc + 1);
        break;
      end
    end
  endtask

  task automatic set_image(input vec_t v);
    mem[0] = v.w0; mem[1] = v.w1; mem[2] = v.w2; mem[3] = v.w3; mem[4] = v.cs;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    bit tim;
    rst_n = 1'b0;
    load_start = 1'b0;
    test_start = 1'b0;
    for (int i = 0; i <= N; i++) mem[i] = '0;
    do_reset();

    // R10: reset state
    chk(!load_busy && !test_busy, "R10", "busy after reset", {load_busy, test_busy}, 0);
    chk(!fail_flag, "R10", "fail after reset", fail_flag, 0);
    chk(!rd_req && !cfg_we, "R10", "req/we after reset", {rd_req, cfg_we}, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      lat = i % 3;
      set_image(v);
      start_op(v.is_load);
      chk(v.is_load ? (load_busy && !test_busy) : (test_busy && !load_busy), "R7",
          "busy after start", {load_busy, test_busy}, v.is_load ? 2 : 1);
      wait_done(tim);
      chk(tim, "R7", "busy fall timing", cyc, issue_cyc + 1);
      chk(fail_flag == v.exp_fail, "R1/R2/R3", "fail result", fail_flag, v.exp_fail);
      chk(addr_err == 0 && resp_next == N + 1, "R4", "read order/count", resp_next, N + 1);
      if (v.is_load) begin
        chk(wr_cnt == N, "R5/R11", "write count in load", wr_cnt, N);
        chk(wr_err == 0, "R5", "write content", wr_err, 0);
      end else begin
        chk(wr_cnt == 0, "R6", "write count in test", wr_cnt, 0);
      end
    end

    // R8: start requests during a running test are ignored
    lat = 2;
    set_image(VECS[0]);
    start_op(1'b0);
    repeat (3) @(negedge clk);
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    chk(!load_busy && test_busy, "R8", "load start during test", {load_busy, test_busy}, 1);
    test_start = 1'b1;
    @(negedge clk);
    test_start = 1'b0;
    wait_done(tim);
    chk(addr_err == 0 && resp_next == N + 1, "R8", "no restart of reads", resp_next, N + 1);
    chk(wr_cnt == 0 && !fail_flag, "R8", "no writes, pass ok", {wr_cnt[7:0], fail_flag}, 0);

    // R9: fail holds while idle, clears on new start
    set_image(VECS[2]);
    start_op(1'b0);
    wait_done(tim);
    repeat (10) @(negedge clk);
    chk(fail_flag, "R9", "fail held idle", fail_flag, 1);
    set_image(VECS[0]);
    start_op(1'b0);
    chk(!fail_flag, "R9", "fail cleared at start", fail_flag, 0);
    wait_done(tim);
    chk(!fail_flag, "R9", "good pass after bad", fail_flag, 0);

    // R11 again with short latency, then R10 reset mid-pass
    lat = 0;
    set_image(VECS[3]);
    start_op(1'b1);
    wait_done(tim);
    chk(wr_cnt == N && wr_err == 0 && fail_flag, "R11", "writes kept, fail set",
        {wr_cnt[7:0], fail_flag}, {8'(N), 1'b1});
    lat = 3;
    set_image(VECS[1]);
    start_op(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!load_busy && !test_busy && !rd_req && !cfg_we && !fail_flag, "R10",
        "mid-pass reset", {load_busy, test_busy, rd_req, cfg_we, fail_flag}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!load_busy && !rd_req, "R10", "idle after reset release", {load_busy, rd_req}, 0);

    summary();
    $finish;
  end

endmodule